// File: doc/BRIEF.md
# Timebase-Tapped Watchdog Timer

This block guards against runaway software. It takes no clock divider of its own. Instead it watches one bit of a free-running timebase counter and counts each carry of that bit, meaning each falling edge of the bit. There are two timebases. One is driven by the main oscillator and one by the sub-clock. A source-select bit and a two-bit interval field choose which timebase bit is used. Once started, the watchdog must be cleared again and again. If software stops clearing it, the block emits a single-cycle reset request toward the CPU reset logic.

The counter that holds the elapsed periods is only two bits wide. A one-bit phase flag is added to it, and this flag is sampled at each start or clear. Together they place the timeout between 3.5 and 4.5 tap periods after the last clear, whatever the phase of the timebase at that moment. A clear of the timebase pushes the next carry later, so the timeout can stretch past the window. This stretch is accepted as it is. Once running, the watchdog can be stopped only by the system reset or by its own timeout.

Top module: `wdt_top`

## Requirements
- R1: After reset the watchdog is stopped. Without a start strobe, `wdt_rst_o` stays low whatever the timebases do.
- R2: With `src_sel_i`=0 (main timebase), `ivl_sel_i` values 0,1,2,3 select count periods of 2^MAIN_LOG[0..3] main timebase counts. The bench uses 16, 32, 64 and 256. After a start or clear at any phase, the reset pulse arrives between 3.5 and 4.5 count periods later. The bench allows a tolerance of 3 clock cycles for register latency.
- R3: With `src_sel_i`=1 (sub timebase), `ivl_sel_i` values 0..3 select count periods of 2^SUB_LOG[0..3] sub timebase counts. The bench uses 16, 32, 64 and 128 clocks. The same 3.5 to 4.5 period window applies.
- R4: A clear strobe while running restarts the window. Clears issued at most 3 periods apart never let a reset pulse through.
- R5: The reset pulse lasts exactly one clock. Afterwards the watchdog is stopped and gives no further pulse until the next start.
- R6: A clear strobe while stopped has no effect. It does not start the watchdog, and no pulse follows.
- R7: Source and interval are captured by the start strobe that leaves the stopped state. Changing `src_sel_i` or `ivl_sel_i` while running does not change the timeout.
- R8: A start strobe while running acts only as a clear. It restarts the window with the interval already captured.
- R9: A timebase clear strobe (`tb_clear_i`) produces no carry, even when the selected bit drops from 1 to 0 because of it. Timebase clears every 0.75 period hold off the timeout indefinitely. After they stop, the timeout follows within 5 periods plus 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; both timebases are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| main_tb_i | input | MAIN_W | Main-oscillator timebase counter value |
| sub_tb_i | input | SUB_W | Sub-clock timebase counter value |
| src_sel_i | input | 1 | Timebase source: 0 main, 1 sub |
| ivl_sel_i | input | 2 | Interval index within the chosen source |
| start_i | input | 1 | Start strobe (clear when already running) |
| clear_i | input | 1 | Watchdog clear strobe |
| tb_clear_i | input | 1 | Strobe marking that the timebases are zeroed at this edge |
| wdt_rst_o | output | 1 | Single-cycle watchdog reset request |

## Verification
The assertions take for granted that both timebase inputs are already synchronous to `clk`. They also assume that a timebase clear strobe coincides with the edge at which the timebase counters read zero. Neither timebase may change its selected bit more than once per tap period. The bench keeps to these conditions. It builds both timebases as counters clocked by `clk`, one counting every cycle and one every fourth cycle. Its timebase clear zeroes both counters at the same edge that the strobe is sampled. Clear and start strobes are placed at random phases of the tap period, so the early and late edges of the window are both reached.

// File: rtl/wdt_pkg.sv
// Shared types and helpers for the timebase-tapped watchdog.
// Assumes tap tables are packed as four LOG_BITS-wide fields, index 0 lowest.
package wdt_pkg;

    localparam int LOG_BITS = 5;

    // Captured selection: source bit above the two interval bits.
    typedef struct packed {
        logic       src;
        logic [1:0] ivl;
    } wdt_cfg_t;

    // Bit index of the timebase bit whose falling edge repeats every 2^log counts.
    function automatic int tap_bit_index(logic [4*LOG_BITS-1:0] logs, int idx);
        return int'(logs[idx*LOG_BITS +: LOG_BITS]) - 1;
    endfunction

endpackage

// File: rtl/wdt_tap_sel.sv
// Tap multiplexer and carry detector.
// Picks one of eight timebase bits and flags the cycle where it falls.
// Assumes a timebase clear zeroes both timebases at the edge where tb_clr is high,
// so the drop caused by that clear must not count as a carry.
module wdt_tap_sel
    import wdt_pkg::*;
#(
    parameter int                    MAIN_W    = 19,
    parameter int                    SUB_W     = 15,
    parameter logic [4*LOG_BITS-1:0] MAIN_LOGS = {5'd19, 5'd16, 5'd14, 5'd12},
    parameter logic [4*LOG_BITS-1:0] SUB_LOGS  = {5'd15, 5'd14, 5'd13, 5'd10}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] main_tb,
    input  logic [SUB_W-1:0]  sub_tb,
    input  wdt_cfg_t          sel,
    input  logic              tb_clr,
    output logic              tap_bit,
    output logic              carry
);

    localparam int N_TAPS = 8;

    logic [N_TAPS-1:0] taps;
    logic              prev_q;

    // Gather the four main and four sub taps into one vector.
    for (genvar i = 0; i < 4; i++) begin : g_taps
        localparam int MPOS = tap_bit_index(MAIN_LOGS, i);
        localparam int SPOS = tap_bit_index(SUB_LOGS, i);
        assign taps[i]     = main_tb[MPOS];
        assign taps[4 + i] = sub_tb[SPOS];
    end

    assign tap_bit = taps[sel];

    // Remember the tap value; a timebase clear forces the history to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= 1'b0;
        else if (tb_clr) prev_q <= 1'b0;
        else             prev_q <= tap_bit;
    end

    assign carry = prev_q & ~tap_bit;

endmodule

// File: rtl/wdt_cfg.sv
// Selection capture.
// Latches source and interval on the start that leaves the stopped state,
// and forwards the incoming selection during that same cycle.
module wdt_cfg
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     start,
    input  wdt_cfg_t cfg_in,
    output wdt_cfg_t cfg_q,
    output wdt_cfg_t sel
);

    logic capture;
    assign capture = start & ~run;

    // Hold the selection for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (capture) cfg_q <= cfg_in;
    end

    assign sel = capture ? cfg_in : cfg_q;

endmodule

// File: rtl/wdt_ctrl.sv
// Run state, two-bit period counter, phase flag and reset pulse.
// Assumes carry is a one-cycle strobe per tap period.
// A start or clear taken while the tap bit is high (second half of a period)
// sets the phase flag, which swallows one carry. This keeps the timeout within 3.5..4.5 periods.
module wdt_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       clear,
    input  logic       carry,
    input  logic       tap_bit,
    output logic       run,
    output logic [1:0] cnt,
    output logic       wdt_rst
);

    localparam logic [1:0] CNT_LAST = 2'd3;

    logic restart;
    logic fire;

    assign restart = start | (clear & run);
    assign fire    = run & ~restart & carry & ~late_q & (cnt == CNT_LAST);

    logic late_q;

    // Track run state, count carries and apply the phase skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            cnt    <= '0;
            late_q <= 1'b0;
        end else if (restart) begin
            run    <= 1'b1;
            cnt    <= '0;
            late_q <= tap_bit;
        end else if (run && carry) begin
            if (late_q) begin
                late_q <= 1'b0;
            end else if (cnt == CNT_LAST) begin
                run <= 1'b0;
                cnt <= '0;
            end else begin
                cnt <= cnt + 2'd1;
            end
        end
    end

    // Register the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) wdt_rst <= 1'b0;
        else        wdt_rst <= fire;
    end

endmodule

// File: rtl/wdt_top.sv
// Timebase-tapped watchdog top.
// Assumes both timebases are synchronous to clk and that tb_clear_i is high
// at the edge where the timebases are zeroed.
module wdt_top
    import wdt_pkg::*;
#(
    parameter int                    MAIN_W    = 19,
    parameter int                    SUB_W     = 15,
    parameter logic [4*LOG_BITS-1:0] MAIN_LOGS = {5'd19, 5'd16, 5'd14, 5'd12},
    parameter logic [4*LOG_BITS-1:0] SUB_LOGS  = {5'd15, 5'd14, 5'd13, 5'd10}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] main_tb_i,
    input  logic [SUB_W-1:0]  sub_tb_i,
    input  logic              src_sel_i,
    input  logic [1:0]        ivl_sel_i,
    input  logic              start_i,
    input  logic              clear_i,
    input  logic              tb_clear_i,
    output logic              wdt_rst_o
);

    wdt_cfg_t   cfg_in;
    wdt_cfg_t   cfg_w;
    wdt_cfg_t   sel_w;
    logic       run_w;
    logic [1:0] cnt_w;
    logic       tap_w;
    logic       carry_w;

    assign cfg_in = '{src: src_sel_i, ivl: ivl_sel_i};

    wdt_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_w),
        .start  (start_i),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_w),
        .sel    (sel_w)
    );

    wdt_tap_sel #(
        .MAIN_W    (MAIN_W),
        .SUB_W     (SUB_W),
        .MAIN_LOGS (MAIN_LOGS),
        .SUB_LOGS  (SUB_LOGS)
    ) u_tap (
        .clk     (clk),
        .rst_n   (rst_n),
        .main_tb (main_tb_i),
        .sub_tb  (sub_tb_i),
        .sel     (sel_w),
        .tb_clr  (tb_clear_i),
        .tap_bit (tap_w),
        .carry   (carry_w)
    );

    wdt_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .clear   (clear_i),
        .carry   (carry_w),
        .tap_bit (tap_w),
        .run     (run_w),
        .cnt     (cnt_w),
        .wdt_rst (wdt_rst_o)
    );

endmodule

// File: rtl/wdt_chk.sv
// Assertion checker for wdt_top, attached by bind.
// Assumes the input conditions stated in the brief.
module wdt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       clear_i,
    input logic       tb_clear_i,
    input logic       wdt_rst_o,
    input logic       run,
    input logic [1:0] cnt,
    input logic       carry,
    input logic [2:0] cfg
);

    // R1: a pulse needs a running watchdog in the cycle before.
    assert_pulse_needs_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> $past(run));

    // R5: the pulse is one cycle wide and leaves the watchdog stopped.
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> !wdt_rst_o);

    assert_stop_after_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> !run);

    // R4: a clear or start leaves the counter at zero.
    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(clear_i) || $past(start_i)) && run) |-> (cnt == 2'd0));

    // R7: the captured selection holds through a run.
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(cfg));

    // R9: the edge after a timebase clear yields no carry.
    assert_tbclr_no_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tb_clear_i) |-> !carry);

endmodule

bind wdt_top wdt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .clear_i    (clear_i),
    .tb_clear_i (tb_clear_i),
    .wdt_rst_o  (wdt_rst_o),
    .run        (run_w),
    .cnt        (cnt_w),
    .carry      (carry_w),
    .cfg        (cfg_w)
);

// File: tb/sim_wdt_top.sv
module sim_wdt_top;

    localparam int MAIN_W = 8;
    localparam int SUB_W  = 5;
    localparam int SUBDIV = 4;
    localparam int TOL    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MAIN_W-1:0] main_tb = '0;
    logic [SUB_W-1:0]  sub_tb = '0;
    logic [1:0]        div = '0;
    logic              src_sel = 1'b0;
    logic [1:0]        ivl_sel = 2'd0;
    logic              start = 1'b0;
    logic              clear = 1'b0;
    logic              tb_clear = 1'b0;
    logic              wdt_rst_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wdt_top #(
        .MAIN_W    (MAIN_W),
        .SUB_W     (SUB_W),
        .MAIN_LOGS ({5'd8, 5'd6, 5'd5, 5'd4}),
        .SUB_LOGS  ({5'd5, 5'd4, 5'd3, 5'd2})
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .main_tb_i  (main_tb),
        .sub_tb_i   (sub_tb),
        .src_sel_i  (src_sel),
        .ivl_sel_i  (ivl_sel),
        .start_i    (start),
        .clear_i    (clear),
        .tb_clear_i (tb_clear),
        .wdt_rst_o  (wdt_rst_o)
    );

    // Free-running timebases; the sub timebase advances every SUBDIV cycles.
    always @(posedge clk) begin
        if (tb_clear) begin
            main_tb <= '0;
            sub_tb  <= '0;
            div     <= '0;
        end else begin
            main_tb <= main_tb + 1'b1;
            div     <= div + 1'b1;
            if (div == 2'(SUBDIV - 1)) sub_tb <= sub_tb + 1'b1;
        end
    end

    // Period in clock cycles for a selection, from the requirements.
    function automatic int period(input bit s, input int iv);
        int mlog[4] = '{4, 5, 6, 8};
        int slog[4] = '{2, 3, 4, 5};
        return s ? (1 << slog[iv]) * SUBDIV : (1 << mlog[iv]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp_lo, input int exp_hi);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, exp_lo, exp_hi);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 0; clear = 0; tb_clear = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic strobe_start(input bit s, input int iv);
        @(negedge clk);
        src_sel = s; ivl_sel = 2'(iv); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic strobe_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    // Cycles until the pulse is seen (starting one cycle after the strobe), or -1.
    task automatic wait_pulse(input int maxc, output int dt);
        dt = -1;
        if (wdt_rst_o) begin
            dt = 0;
            return;
        end
        for (int k = 1; k <= maxc; k++) begin
            @(negedge clk);
            if (wdt_rst_o) begin
                dt = k;
                break;
            end
        end
    endtask

    task automatic idle_rand(input int p);
        repeat ($urandom_range(0, p - 1)) @(negedge clk);
    endtask

    task automatic t_reset();
        int dt;
        do_reset();
        chk(wdt_rst_o == 1'b0, "R1 reset output", int'(wdt_rst_o), 0, 0);
        wait_pulse(2000, dt);
        chk(dt == -1, "R1 no pulse without start", dt, -1, -1);
    endtask

    task automatic t_clear_stopped();
        int dt;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            idle_rand(64);
            strobe_clear();
        end
        wait_pulse(1500, dt);
        chk(dt == -1, "R6 clear while stopped", dt, -1, -1);
    endtask

    task automatic t_window(input bit s, input int iv);
        int p, dt, lo, hi;
        string tag;
        p  = period(s, iv);
        lo = (7 * p) / 2 - TOL;
        hi = (9 * p) / 2 + TOL;
        tag = s ? "R3 sub window" : "R2 main window";
        do_reset();
        for (int r = 0; r < 3; r++) begin
            idle_rand(p);
            strobe_start(s, iv);
            wait_pulse(hi + 10, dt);
            chk(dt >= lo && dt <= hi, tag, dt, lo, hi);
            @(negedge clk);
            chk(wdt_rst_o == 1'b0, "R5 pulse width", int'(wdt_rst_o), 0, 0);
        end
        // Window measured from a clear given part-way through a run.
        strobe_start(s, iv);
        repeat (p + int'($urandom_range(0, p))) @(negedge clk);
        strobe_clear();
        wait_pulse(hi + 10, dt);
        chk(dt >= lo && dt <= hi, tag, dt, lo, hi);
    endtask

    task automatic t_stopped_after(input bit s, input int iv);
        int p, dt;
        p = period(s, iv);
        do_reset();
        strobe_start(s, iv);
        wait_pulse(5 * p + 10, dt);
        chk(dt > 0, "R5 first pulse", dt, 1, 5 * p);
        @(negedge clk);
        wait_pulse(8 * p, dt);
        chk(dt == -1, "R5 stopped after pulse", dt, -1, -1);
    endtask

    task automatic t_periodic(input bit s, input int iv);
        int p, dt;
        bit seen;
        p = period(s, iv);
        seen = 1'b0;
        do_reset();
        strobe_start(s, iv);
        for (int i = 0; i < 20; i++) begin
            for (int k = 0; k < int'($urandom_range(p, 3 * p)); k++) begin
                @(negedge clk);
                if (wdt_rst_o) seen = 1'b1;
            end
            strobe_clear();
            if (wdt_rst_o) seen = 1'b1;
        end
        chk(!seen, "R4 periodic clears hold off", int'(seen), 0, 0);
        wait_pulse(5 * p, dt);
        chk(dt > 0, "R4 expires after clears stop", dt, 1, 5 * p);
    endtask

    task automatic t_latch();
        int p, dt, lo, hi;
        p  = period(0, 0);
        lo = (7 * p) / 2 - TOL;
        hi = (9 * p) / 2 + TOL;
        do_reset();
        strobe_start(0, 0);
        @(negedge clk);
        src_sel = 1'b1; ivl_sel = 2'd3;
        wait_pulse(hi + 10, dt);
        chk(dt >= lo - 2 && dt <= hi, "R7 selection latched", dt, lo, hi);
    endtask

    task automatic t_restart();
        int p, dt, lo, hi;
        p  = period(0, 0);
        lo = (7 * p) / 2 - TOL;
        hi = (9 * p) / 2 + TOL;
        do_reset();
        strobe_start(0, 0);
        repeat (30) @(negedge clk);
        strobe_start(0, 3);
        wait_pulse(hi + 10, dt);
        chk(dt >= lo && dt <= hi, "R8 start while running", dt, lo, hi);
    endtask

    task automatic t_tbclr();
        int p, dt;
        bit seen;
        p = period(0, 1);
        seen = 1'b0;
        do_reset();
        strobe_start(0, 1);
        for (int i = 0; i < 20; i++) begin
            for (int k = 0; k < (3 * p) / 4 - 1; k++) begin
                @(negedge clk);
                if (wdt_rst_o) seen = 1'b1;
            end
            tb_clear = 1'b1;
            @(negedge clk);
            tb_clear = 1'b0;
            if (wdt_rst_o) seen = 1'b1;
        end
        chk(!seen, "R9 timebase clear gives no carry", int'(seen), 0, 0);
        wait_pulse(5 * p + TOL, dt);
        chk(dt > 0, "R9 timeout after timebase clears", dt, 1, 5 * p + TOL);
    endtask

    initial begin
        t_reset();
        t_clear_stopped();
        for (int iv = 0; iv < 4; iv++) t_window(1'b0, iv);
        for (int iv = 0; iv < 4; iv++) t_window(1'b1, iv);
        t_stopped_after(1'b1, 0);
        t_periodic(1'b0, 2);
        t_periodic(1'b1, 1);
        t_latch();
        t_restart();
        t_tbclr();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule